// File: doc/BRIEF.md
# Three-Least-Reliable Selector

This block looks at a vector of soft-value magnitudes, one per lane, and returns the three smallest of them together with the lane numbers they came from. The results come out in ascending order. A Chase-style soft-in soft-out decoder uses these three positions to choose which bits to flip when it builds its test patterns. The block does not produce a complete ordering of the lanes. It finds only the three lowest.

The selection is a tree of merge nodes. Each leaf is one lane, carried as a key made of its magnitude and its lane number. Every internal node merges two sorted triples from the level below into the sorted three smallest of their union. One level of pairwise minima feeds a three-element compare-and-select sort. Lane numbers travel inside the key, below the magnitude. So on equal magnitudes the lower lane wins, and the result is deterministic.

The block has no state machine. It has a single result register that can be left out by parameter. When the register is present, a new vector is captured only on a cycle where `in_vld` is high. The captured result then holds until the next valid vector.

Top module: `tmin3_sorter`

## Requirements
- R1: Output slots 0, 1 and 2 hold the smallest, second smallest and third smallest magnitudes of the captured vector, so slot0 ≤ slot1 ≤ slot2. Slot k occupies `min_mag[k*MAG_W +: MAG_W]`.
- R2: Each reported index is the lane number whose magnitude is reported in the same slot. Lane i is read from `mags[i*MAG_W +: MAG_W]`, and its index is in `min_idx[k*IDX_W +: IDX_W]`.
- R3: When magnitudes are equal, the lane with the lower number is ranked first. For any two slots with equal magnitude, the earlier slot has the smaller index.
- R4: The three reported indices are always distinct. With every lane equal, the indices are 0, 1 and 2.
- R5: With the result register present, a vector applied with `in_vld` high before a rising edge appears at the outputs after that edge. `out_vld` is then high for that cycle.
- R6: During and right after reset, `out_vld` is low and all result outputs are zero.
- R7: When `in_vld` is low at an edge, `out_vld` goes low and the result outputs keep their previous values, whatever the values on `mags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Marks `mags` as a vector to capture |
| mags | input | N_LANES*MAG_W | Lane magnitudes, lane i at bits i*MAG_W |
| out_vld | output | 1 | Result outputs belong to a captured vector |
| min_mag | output | 3*MAG_W | Three smallest magnitudes, slot 0 lowest |
| min_idx | output | 3*IDX_W | Lane numbers for each slot |

## Verification
A wrong merge node ranks a larger value above a smaller one. It then shows at the ports one cycle after capture, either as slots out of order or as a magnitude that does not match the lane it names. A broken tie rule shows as two equal slots in reversed index order, or as a repeated index. Small magnitude ranges give many ties, and these are where such errors appear. A register that loads when it should hold shows as a changed output on the first idle edge.

// File: rtl/tmin3_pkg.sv
package tmin3_pkg;
    localparam int DEF_LANES = 32;
    localparam int DEF_MAG_W = 5;
    localparam int KEEP      = 3;
endpackage

// File: rtl/tmin3_cs.sv
module tmin3_cs #(
    parameter int KW = 11
) (
    input  logic [KW-1:0] a,
    input  logic [KW-1:0] b,
    output logic [KW-1:0] lo,
    output logic [KW-1:0] hi
);
    logic take_b;
    assign take_b = (b < a);
    assign lo = take_b ? b : a;
    assign hi = take_b ? a : b;
endmodule

// File: rtl/tmin3_merge.sv
module tmin3_merge #(
    parameter int KW = 11
) (
    input  logic [2:0][KW-1:0] a,
    input  logic [2:0][KW-1:0] b,
    output logic [2:0][KW-1:0] y
);
    // the three smallest of two sorted triples are pairwise minima of one
    // triple against the other one reversed; they still need ordering
    logic [KW-1:0] c0, c1, c2;
    logic [KW-1:0] p0, p1, q1, q2, r0, r1;

    assign c0 = (b[2] < a[0]) ? b[2] : a[0];
    assign c1 = (b[1] < a[1]) ? b[1] : a[1];
    assign c2 = (b[0] < a[2]) ? b[0] : a[2];

    tmin3_cs #(.KW(KW)) u_s0 (.a(c0), .b(c1), .lo(p0), .hi(p1));
    tmin3_cs #(.KW(KW)) u_s1 (.a(p1), .b(c2), .lo(q1), .hi(q2));
    tmin3_cs #(.KW(KW)) u_s2 (.a(p0), .b(q1), .lo(r0), .hi(r1));

    assign y[0] = r0;
    assign y[1] = r1;
    assign y[2] = q2;
endmodule

// File: rtl/tmin3_tree.sv
module tmin3_tree #(
    parameter int N_LANES = 32,
    parameter int MAG_W   = 5,
    localparam int IDX_W  = $clog2(N_LANES),
    localparam int KW     = 1 + MAG_W + IDX_W
) (
    input  logic [N_LANES*MAG_W-1:0] mags,
    output logic [2:0][KW-1:0]       top
);
    // key = {absent, magnitude, lane}; an absent entry sorts after all lanes
    localparam logic [KW-1:0] ABSENT = '1;

    logic [2:0][KW-1:0] nd [1:2*N_LANES-1];

    genvar gi;
    generate
        for (gi = 0; gi < N_LANES; gi++) begin : g_leaf
            localparam logic [IDX_W-1:0] LANE = IDX_W'(gi);
            assign nd[N_LANES+gi] = {ABSENT, ABSENT,
                                     {1'b0, mags[gi*MAG_W +: MAG_W], LANE}};
        end
        for (gi = 1; gi < N_LANES; gi++) begin : g_node
            tmin3_merge #(.KW(KW)) u_mrg (
                .a(nd[2*gi]),
                .b(nd[2*gi+1]),
                .y(nd[gi])
            );
        end
    endgenerate

    assign top = nd[1];
endmodule

// File: rtl/tmin3_sorter.sv
module tmin3_sorter
    import tmin3_pkg::*;
#(
    parameter int N_LANES = DEF_LANES,
    parameter int MAG_W   = DEF_MAG_W,
    parameter bit REG_OUT = 1'b1,
    localparam int IDX_W  = $clog2(N_LANES),
    localparam int KW     = 1 + MAG_W + IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [N_LANES*MAG_W-1:0] mags,
    output logic                     out_vld,
    output logic [KEEP*MAG_W-1:0]    min_mag,
    output logic [KEEP*IDX_W-1:0]    min_idx
);
    logic [2:0][KW-1:0]        best;
    logic [KEEP-1:0]           absent;
    logic [KEEP*MAG_W-1:0]     mag_c;
    logic [KEEP*IDX_W-1:0]     idx_c;

    tmin3_tree #(.N_LANES(N_LANES), .MAG_W(MAG_W)) u_tree (
        .mags(mags),
        .top (best)
    );

    genvar gk;
    generate
        for (gk = 0; gk < KEEP; gk++) begin : g_slot
            assign absent[gk] = best[gk][KW-1];
            assign mag_c[gk*MAG_W +: MAG_W] = best[gk][IDX_W +: MAG_W];
            assign idx_c[gk*IDX_W +: IDX_W] = best[gk][IDX_W-1:0];
        end

        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_vld <= 1'b0;
                    min_mag <= '0;
                    min_idx <= '0;
                end else begin
                    out_vld <= in_vld;
                    if (in_vld) begin
                        min_mag <= mag_c;
                        min_idx <= idx_c;
                    end
                end
            end

            // R5
            always @(posedge clk) begin
                latency_chk: assert (!rst_n || !$past(rst_n) || out_vld == $past(in_vld))
                    else $error("out_vld does not follow in_vld");
            end

            // R7
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_vld |=> ($stable(min_mag) && $stable(min_idx)));
        end else begin : g_comb
            assign out_vld = in_vld;
            assign min_mag = mag_c;
            assign min_idx = idx_c;
        end
    endgenerate

    // R1
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (min_mag[0 +: MAG_W] <= min_mag[MAG_W +: MAG_W]) &&
                    (min_mag[MAG_W +: MAG_W] <= min_mag[2*MAG_W +: MAG_W]));

    // R3
    tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && min_mag[0 +: MAG_W] == min_mag[MAG_W +: MAG_W]) |->
            (min_idx[0 +: IDX_W] < min_idx[IDX_W +: IDX_W]));

    // R4
    distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (min_idx[0 +: IDX_W] != min_idx[IDX_W +: IDX_W]) &&
                    (min_idx[0 +: IDX_W] != min_idx[2*IDX_W +: IDX_W]) &&
                    (min_idx[IDX_W +: IDX_W] != min_idx[2*IDX_W +: IDX_W]));

    // R2
    always_comb begin
        if (N_LANES >= KEEP) begin
            present_chk: assert (absent == '0)
                else $error("placeholder entry reached the root");
        end
    end
endmodule

// File: tb/tmin3_sorter_test.sv
module tmin3_sorter_test;
    localparam int N  = 32;
    localparam int MW = 5;
    localparam int IW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic [N*MW-1:0]   mags = '0;
    logic              out_vld;
    logic [3*MW-1:0]   min_mag;
    logic [3*IW-1:0]   min_idx;

    int total = 0;
    int bad   = 0;
    int vals [N];
    int exp_m [3];
    int exp_i [3];

    always #5 clk = ~clk;

    tmin3_sorter uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mags(mags),
        .out_vld(out_vld), .min_mag(min_mag), .min_idx(min_idx)
    );

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // reference: full selection ordered by (magnitude, lane)
    task automatic model();
        bit used [N];
        for (int i = 0; i < N; i++) used[i] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            int bi = -1;
            for (int i = 0; i < N; i++)
                if (!used[i] && (bi < 0 || vals[i] < vals[bi])) bi = i;
            used[bi] = 1'b1;
            exp_m[k] = vals[bi];
            exp_i[k] = bi;
        end
    endtask

    task automatic load();
        for (int i = 0; i < N; i++) mags[i*MW +: MW] = MW'(vals[i]);
    endtask

    task automatic apply_and_check(input string tag);
        @(negedge clk);
        load();
        in_vld = 1'b1;
        model();
        @(posedge clk);
        @(negedge clk);
        in_vld = 1'b0;
        check({"R5 out_vld ", tag}, int'(out_vld), 1);
        for (int k = 0; k < 3; k++) begin
            check({"R1 R3 mag ", tag}, int'(min_mag[k*MW +: MW]), exp_m[k]);
            check({"R2 R4 idx ", tag}, int'(min_idx[k*IW +: IW]), exp_i[k]);
        end
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int prev_m;
        int prev_i;
        void'($urandom(32'd2718));
        repeat (2) @(negedge clk);
        // R6 reset state
        check("R6 out_vld", int'(out_vld), 0);
        check("R6 min_mag", int'(min_mag), 0);
        check("R6 min_idx", int'(min_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 after release", int'(out_vld), 0);

        // R4 all equal
        for (int i = 0; i < N; i++) vals[i] = 7;
        apply_and_check("all equal");
        for (int i = 0; i < N; i++) vals[i] = 0;
        apply_and_check("all zero");
        for (int i = 0; i < N; i++) vals[i] = 31;
        apply_and_check("all max");
        // R2 descending, minima at top lanes
        for (int i = 0; i < N; i++) vals[i] = 31 - i;
        apply_and_check("descending");
        for (int i = 0; i < N; i++) vals[i] = i;
        apply_and_check("ascending");
        // R3 tie between distant lanes
        for (int i = 0; i < N; i++) vals[i] = 20;
        vals[31] = 2; vals[3] = 2; vals[17] = 1; vals[30] = 2;
        apply_and_check("distant ties");
        // both of the two smallest in the same leaf pair
        for (int i = 0; i < N; i++) vals[i] = 25;
        vals[8] = 4; vals[9] = 3; vals[10] = 5;
        apply_and_check("clustered");

        // R7 hold: change inputs with in_vld low
        prev_m = int'(min_mag);
        prev_i = int'(min_idx);
        @(negedge clk);
        for (int i = 0; i < N; i++) vals[i] = 0;
        load();
        @(posedge clk);
        @(negedge clk);
        check("R7 out_vld low", int'(out_vld), 0);
        check("R7 mag held", int'(min_mag), prev_m);
        check("R7 idx held", int'(min_idx), prev_i);

        // random: narrow range for heavy ties, then full range
        for (int t = 0; t < 300; t++) begin
            for (int i = 0; i < N; i++) vals[i] = int'($urandom_range(0, 3));
            apply_and_check("rand narrow");
        end
        for (int t = 0; t < 300; t++) begin
            for (int i = 0; i < N; i++) vals[i] = int'($urandom_range(0, 31));
            apply_and_check("rand full");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule